// File: doc/BRIEF.md
# Asynchronous Byte-Wide SRAM Access Controller

This block sits between a synchronous host and an external asynchronous static RAM that has 20 address bits and 8 data bits (1M byte locations). The host raises a request with a direction bit, an address and, for writes, a byte. The controller turns that request into a correctly timed sequence on the memory's active-low chip-select, output-enable and write-strobe pins. It drives the shared data lines only through a separate output value and tri-state enable. It finishes each access with a one-cycle acknowledge, and on reads the returned byte is held in a register.

Every nanosecond figure of the memory is a parameter. Each figure is converted at elaboration into a whole number of system clocks with cycles(x) = max(1, ceil(x / CLK_NS)). The derived counts are: RD_CYC = cycles(T_AA_NS), SET_CYC = cycles(T_HZ_NS), PWR_CYC = cycles(PWRUP_NS), and STB_CYC = max(cycles(T_PWE_NS), cycles(T_SD_NS), cycles(T_WC_NS) - SET_CYC - 1).

Writes are strobe-controlled: chip-select stays low for the whole write, and output-enable stays high for the whole write. After reset the controller refuses all traffic for the power-up interval. Between accesses chip-select is high, so the memory falls into its automatic standby.

Top module: `sram_async_ctrl`

## Requirements
- R1: While reset is high, and for the first PWR_CYC clock edges after it falls, mem_ce_n, mem_oe_n and mem_we_n are 1, mem_dq_oe and host_ack are 0, host_busy is 1, host_rdata is 0, and a request makes no memory pin move.
- R2: With no access in progress, mem_ce_n is 1, mem_oe_n is 1, mem_we_n is 1, mem_dq_oe is 0 and host_busy is 0.
- R3: A read accepted at an edge (host_req=1, host_we=0, host_busy=0) gives RD_CYC cycles with mem_ce_n=0, mem_oe_n=0, mem_we_n=1, mem_dq_oe=0 and mem_addr equal to the request address.
- R4: The byte on mem_dq_in in the last read cycle appears on host_rdata in the next cycle. In that same cycle host_ack=1, mem_ce_n=1 and mem_oe_n=1.
- R5: A write accepted at an edge (host_we=1) first gives SET_CYC cycles with mem_ce_n=0, mem_oe_n=1, mem_we_n=1, mem_dq_oe=0 and mem_addr equal to the request address.
- R6: The setup cycles are followed by STB_CYC cycles with mem_we_n=0, mem_dq_oe=1 and mem_dq_out equal to the request byte, with mem_ce_n=0 and mem_oe_n=1.
- R7: After the strobe there is one cycle with mem_we_n=1, mem_ce_n=0 and mem_dq_oe=1, with the byte unchanged. The next cycle has mem_dq_oe=0, mem_ce_n=1 and host_ack=1.
- R8: host_ack is high for exactly one cycle per accepted request, and host_busy is 0 in that cycle. A request held high is accepted in that cycle.
- R9: mem_we_n and mem_oe_n are never both 0. mem_dq_oe is never 1 while mem_oe_n is 0 or mem_ce_n is 1.
- R10: While mem_ce_n stays 0, mem_addr does not change.
- R11: A request raised while host_busy is 1 is dropped, not queued. No memory pin reacts to it.
- R12: host_rdata keeps the last read byte until the next read completes. Writes leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| host_req | input | 1 | Access request, sampled when host_busy is 0 |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 20 | Byte address |
| host_wdata | input | 8 | Write byte |
| host_rdata | output | 8 | Last byte read |
| host_ack | output | 1 | One-cycle completion pulse |
| host_busy | output | 1 | Controller locked or mid-access |
| mem_addr | output | 20 | Memory address pins |
| mem_ce_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_dq_out | output | 8 | Value for the data lines when driven |
| mem_dq_oe | output | 1 | Tri-state enable of the data lines |
| mem_dq_in | input | 8 | Value seen on the data lines |

## Verification
The acknowledge of one access and the acceptance of the next can fall in the same cycle. The bench provokes this by keeping host_req high across an acknowledge, so that a second read or write starts at the very edge where the first one completes. The reference model checks that the acknowledge cycle still shows the memory deselected, and that the returned byte belongs to the first access. It also checks that the new strobe sequence begins on the following cycle. A second collision, a request arriving mid-access or during the power-up lock, is judged by checking that no pin deviates from the expected sequence.

// File: rtl/sram_ctrl_pkg.sv
`timescale 1ns/1ps
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_LOCK  = 3'd0,
    ST_IDLE  = 3'd1,
    ST_RD    = 3'd2,
    ST_WSET  = 3'd3,
    ST_WSTB  = 3'd4,
    ST_WHOLD = 3'd5
  } ctrl_state_t;

  // whole clocks covering a nanosecond figure, never fewer than one
  function automatic int cyc_of(input int ns, input int clk_ns);
    int c;
    c = (ns + clk_ns - 1) / clk_ns;
    if (c < 1) c = 1;
    return c;
  endfunction

  function automatic int max_of(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_pwrup_gate.sv
`timescale 1ns/1ps
module sram_pwrup_gate #(
  parameter int PWR_CYC = 10000
) (
  input  logic clk,
  input  logic rst,
  output logic done
);
  localparam int PW = $clog2(PWR_CYC + 1);
  localparam logic [PW-1:0] START = PW'(PWR_CYC - 1);

  logic [PW-1:0] remain;

  always_ff @(posedge clk) begin
    if (rst)              remain <= START;
    else if (remain != '0) remain <= remain - 1'b1;
  end

  assign done = (remain == '0);
endmodule

// File: rtl/sram_wait_cnt.sv
`timescale 1ns/1ps
module sram_wait_cnt #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (load)        cnt <= load_val;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/sram_host_latch.sv
`timescale 1ns/1ps
module sram_host_latch #(
  parameter int AW = 20,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          accept,
  input  logic          capture,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic [DW-1:0] bus_in,
  output logic [AW-1:0] addr_q,
  output logic [DW-1:0] wdata_q,
  output logic [DW-1:0] rdata_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      if (accept) begin
        addr_q  <= req_addr;
        wdata_q <= req_wdata;
      end
      if (capture) rdata_q <= bus_in;
    end
  end
endmodule

// File: rtl/sram_async_ctrl.sv
`timescale 1ns/1ps
module sram_async_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W   = 20,
  parameter int DATA_W   = 8,
  parameter int CLK_NS   = 10,
  parameter int T_AA_NS  = 10,
  parameter int T_PWE_NS = 7,
  parameter int T_SD_NS  = 5,
  parameter int T_HZ_NS  = 5,
  parameter int T_WC_NS  = 10,
  parameter int PWRUP_NS = 100000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_req,
  input  logic              host_we,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  output logic              host_ack,
  output logic              host_busy,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in
);
  localparam int RD_CYC  = cyc_of(T_AA_NS, CLK_NS);
  localparam int SET_CYC = cyc_of(T_HZ_NS, CLK_NS);
  localparam int WC_CYC  = cyc_of(T_WC_NS, CLK_NS);
  localparam int STB_CYC = max_of(max_of(cyc_of(T_PWE_NS, CLK_NS), cyc_of(T_SD_NS, CLK_NS)),
                                  WC_CYC - SET_CYC - 1);
  localparam int PWR_CYC = cyc_of(PWRUP_NS, CLK_NS);
  localparam int MAXC    = max_of(max_of(RD_CYC, SET_CYC), STB_CYC);
  localparam int CW      = $clog2(MAXC + 1);
  localparam logic [CW-1:0] RD_M1  = CW'(RD_CYC - 1);
  localparam logic [CW-1:0] SET_M1 = CW'(SET_CYC - 1);
  localparam logic [CW-1:0] STB_M1 = CW'(STB_CYC - 1);

  ctrl_state_t state, nxt;
  logic        pw_done, cnt_zero, cnt_load, accept, capture, ack_set;
  logic [CW-1:0] ld_val;

  sram_pwrup_gate #(.PWR_CYC(PWR_CYC)) u_pwr (
    .clk(clk), .rst(rst), .done(pw_done)
  );

  sram_wait_cnt #(.W(CW)) u_cnt (
    .clk(clk), .rst(rst), .load(cnt_load), .load_val(ld_val), .zero(cnt_zero)
  );

  sram_host_latch #(.AW(ADDR_W), .DW(DATA_W)) u_latch (
    .clk(clk), .rst(rst), .accept(accept), .capture(capture),
    .req_addr(host_addr), .req_wdata(host_wdata), .bus_in(mem_dq_in),
    .addr_q(mem_addr), .wdata_q(mem_dq_out), .rdata_q(host_rdata)
  );

  always_comb begin
    nxt      = state;
    cnt_load = 1'b0;
    ld_val   = '0;
    accept   = 1'b0;
    capture  = 1'b0;
    ack_set  = 1'b0;
    unique case (state)
      ST_LOCK:  if (pw_done) nxt = ST_IDLE;
      ST_IDLE: begin
        if (host_req) begin
          accept   = 1'b1;
          cnt_load = 1'b1;
          ld_val   = host_we ? SET_M1 : RD_M1;
          nxt      = host_we ? ST_WSET : ST_RD;
        end
      end
      ST_RD: begin
        if (cnt_zero) begin
          capture = 1'b1;
          ack_set = 1'b1;
          nxt     = ST_IDLE;
        end
      end
      ST_WSET: begin
        if (cnt_zero) begin
          cnt_load = 1'b1;
          ld_val   = STB_M1;
          nxt      = ST_WSTB;
        end
      end
      ST_WSTB:  if (cnt_zero) nxt = ST_WHOLD;
      ST_WHOLD: begin
        ack_set = 1'b1;
        nxt     = ST_IDLE;
      end
      default:  nxt = ST_LOCK;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_LOCK;
      mem_ce_n  <= 1'b1;
      mem_oe_n  <= 1'b1;
      mem_we_n  <= 1'b1;
      mem_dq_oe <= 1'b0;
      host_ack  <= 1'b0;
      host_busy <= 1'b1;
    end else begin
      state     <= nxt;
      mem_ce_n  <= !(nxt == ST_RD || nxt == ST_WSET || nxt == ST_WSTB || nxt == ST_WHOLD);
      mem_oe_n  <= (nxt != ST_RD);
      mem_we_n  <= (nxt != ST_WSTB);
      mem_dq_oe <= (nxt == ST_WSTB || nxt == ST_WHOLD);
      host_ack  <= ack_set;
      host_busy <= (nxt != ST_IDLE);
    end
  end

  // R9
  no_we_oe_overlap_chk: assert property (@(posedge clk) disable iff (rst)
    !(!mem_we_n && !mem_oe_n));

  // R9
  no_drive_on_read_chk: assert property (@(posedge clk) disable iff (rst)
    mem_dq_oe |-> (mem_oe_n && !mem_ce_n));

  // R8
  ack_single_chk: assert property (@(posedge clk) disable iff (rst)
    host_ack |=> !host_ack);

  // R8
  ack_not_busy_chk: assert property (@(posedge clk) disable iff (rst)
    host_ack |-> (!host_busy && mem_ce_n));

  // R10
  addr_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (!mem_ce_n && !$past(mem_ce_n)) |-> $stable(mem_addr));

  // R7
  hold_after_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_we_n) |-> (mem_dq_oe && !mem_ce_n && $stable(mem_dq_out)));

  // R1
  lock_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !pw_done |-> (mem_ce_n && host_busy));

endmodule

// File: tb/sram_async_ctrl_bench.sv
`timescale 1ns/1ps
module sram_async_ctrl_bench;
  localparam int CLK_NS = 10;
  localparam int AA = 25, PWE = 18, SD = 5, HZ = 12, WC = 60, PWRUP = 2000;

  function automatic int cyc(input int ns);
    int c;
    c = (ns + CLK_NS - 1) / CLK_NS;
    return (c < 1) ? 1 : c;
  endfunction

  localparam int RD_N  = cyc(AA);
  localparam int SET_N = cyc(HZ);
  localparam int STB_A = (cyc(PWE) > cyc(SD)) ? cyc(PWE) : cyc(SD);
  localparam int STB_N = (STB_A > cyc(WC) - SET_N - 1) ? STB_A : cyc(WC) - SET_N - 1;
  localparam int PWR_N = cyc(PWRUP);

  logic clk = 1'b0, rst = 1'b1;
  logic host_req = 1'b0, host_we = 1'b0;
  logic [19:0] host_addr = '0;
  logic [7:0]  host_wdata = '0;
  logic [7:0]  host_rdata, mem_dq_out;
  logic host_ack, host_busy, mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe;
  logic [19:0] mem_addr;
  logic [7:0]  mem_dq_in = 8'hEE;

  always #5 clk = ~clk;

  sram_async_ctrl #(
    .CLK_NS(CLK_NS), .T_AA_NS(AA), .T_PWE_NS(PWE), .T_SD_NS(SD),
    .T_HZ_NS(HZ), .T_WC_NS(WC), .PWRUP_NS(PWRUP)
  ) u_sram_async_ctrl (
    .clk(clk), .rst(rst), .host_req(host_req), .host_we(host_we),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .host_ack(host_ack), .host_busy(host_busy), .mem_addr(mem_addr),
    .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
    .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
  );

  // behavioural memory responder
  logic [7:0] resp_mem [int];
  logic [7:0] shadow   [int];

  function automatic logic [7:0] blank(input logic [19:0] a);
    return a[7:0] ^ {a[15:12], a[19:16]} ^ 8'h3C;
  endfunction

  always @(posedge clk) begin
    #1;
    if (!mem_ce_n && !mem_we_n && mem_dq_oe) resp_mem[int'(mem_addr)] = mem_dq_out;
    if (!mem_ce_n && !mem_oe_n && mem_we_n)
      mem_dq_in = resp_mem.exists(int'(mem_addr)) ? resp_mem[int'(mem_addr)] : blank(mem_addr);
    else
      mem_dq_in = 8'hEE;
  end

  typedef struct {
    bit ce_n, oe_n, we_n, dq_oe, ack, busy, rd_upd;
    logic [19:0] addr;
    logic [7:0]  dout, rnew;
    string tag;
  } exp_t;

  exp_t q[$];
  int checks = 0, fails = 0, edges = 0;
  logic [7:0] exp_rdata = 8'h00;
  bit done_flag = 0;

  function automatic exp_t idle_e(input bit busy, input string tag);
    exp_t e;
    e.ce_n = 1; e.oe_n = 1; e.we_n = 1; e.dq_oe = 0; e.ack = 0; e.busy = busy;
    e.rd_upd = 0; e.addr = '0; e.dout = '0; e.rnew = '0; e.tag = tag;
    return e;
  endfunction

  task automatic push_seq(input bit we, input logic [19:0] a, input logic [7:0] d);
    exp_t e;
    if (!we) begin
      for (int i = 0; i < RD_N; i++) begin
        e = idle_e(1, "R3"); e.ce_n = 0; e.oe_n = 0; e.addr = a; q.push_back(e);
      end
      e = idle_e(0, "R4");
      e.ack = 1; e.rd_upd = 1;
      e.rnew = shadow.exists(int'(a)) ? shadow[int'(a)] : blank(a);
      q.push_back(e);
    end else begin
      shadow[int'(a)] = d;
      for (int i = 0; i < SET_N; i++) begin
        e = idle_e(1, "R5"); e.ce_n = 0; e.addr = a; q.push_back(e);
      end
      for (int i = 0; i < STB_N; i++) begin
        e = idle_e(1, "R6"); e.ce_n = 0; e.we_n = 0; e.dq_oe = 1; e.addr = a; e.dout = d;
        q.push_back(e);
      end
      e = idle_e(1, "R7"); e.ce_n = 0; e.dq_oe = 1; e.addr = a; e.dout = d; q.push_back(e);
      e = idle_e(0, "R7"); e.ack = 1; q.push_back(e);
    end
  endtask

  // one cycle: compare at the falling edge, then drive the next inputs
  task automatic tick(input bit req, input bit we, input logic [19:0] a,
                      input logic [7:0] d, output bit accepted);
    exp_t e;
    bit bad;
    @(negedge clk);
    if (!rst) edges++;
    if (q.size() > 0) e = q.pop_front();
    else e = idle_e(rst || edges < PWR_N, (rst || edges < PWR_N) ? "R1" : "R2");
    if (e.rd_upd) exp_rdata = e.rnew;
    bad = (mem_ce_n !== e.ce_n) || (mem_oe_n !== e.oe_n) || (mem_we_n !== e.we_n) ||
          (mem_dq_oe !== e.dq_oe) || (host_ack !== e.ack) || (host_busy !== e.busy) ||
          (!e.ce_n && mem_addr !== e.addr) || (e.dq_oe && mem_dq_out !== e.dout) ||
          (host_rdata !== exp_rdata);
    checks++;
    if (bad) begin
      fails++;
      $display("FAIL %s t=%0t ce/oe/we/oe/ack/busy=%b%b%b%b%b%b exp %b%b%b%b%b%b addr=%h exp %h dout=%h exp %h rdata=%h exp %h",
        e.tag, $time, mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe, host_ack, host_busy,
        e.ce_n, e.oe_n, e.we_n, e.dq_oe, e.ack, e.busy, mem_addr, e.addr,
        mem_dq_out, e.dout, host_rdata, exp_rdata);
    end
    accepted = req && !rst && !e.busy;
    host_req = req; host_we = we; host_addr = a; host_wdata = d;
    if (accepted) push_seq(we, a, d);
  endtask

  task automatic access(input bit we, input logic [19:0] a, input logic [7:0] d);
    bit acc = 0;
    while (!acc) tick(1, we, a, d, acc);
  endtask

  task automatic quiet(input int n);
    bit acc;
    for (int i = 0; i < n; i++) tick(0, 0, '0, '0, acc);
  endtask

  task automatic drain;
    bit acc;
    while (q.size() > 0) tick(0, 0, '0, '0, acc);
  endtask

  initial begin
    bit acc;
    logic [19:0] la;
    // R1: reset state held while reset is asserted
    for (int i = 0; i < 3; i++) tick(0, 0, '0, '0, acc);
    rst = 1'b0;
    quiet(3);
    // R1 and R11: a request during the power-up lock is ignored
    tick(1, 0, 20'h00010, 8'h00, acc);
    tick(1, 1, 20'h00020, 8'h77, acc);
    while (edges < PWR_N + 1) tick(0, 0, '0, '0, acc);
    // R2: idle after lock; R3/R4: read of an unwritten cell
    access(0, 20'h00000, 8'h00); drain; quiet(2);
    // R5/R6/R7: write then read back
    access(1, 20'hABCDE, 8'h5A); drain; quiet(1);
    access(0, 20'hABCDE, 8'h00); drain;
    // R12: a write leaves host_rdata alone
    access(1, 20'h12345, 8'hC3); drain;
    // boundary addresses and data
    access(1, 20'hFFFFF, 8'hFF); drain;
    access(1, 20'h00000, 8'h00); drain;
    access(0, 20'hFFFFF, 8'h00); drain;
    access(0, 20'h00000, 8'h00); drain;
    // R11: second request mid-access is dropped
    access(1, 20'h00555, 8'hA5);
    tick(1, 0, 20'h00AAA, 8'h00, acc);
    tick(1, 1, 20'h00AAA, 8'h11, acc);
    tick(0, 0, '0, '0, acc);
    drain;
    // R8: request held high across ack, back-to-back accesses
    access(0, 20'h00555, 8'h00);
    access(1, 20'h00556, 8'h3E);
    access(0, 20'h00556, 8'h00);
    access(0, 20'hABCDE, 8'h00);
    drain; quiet(2);
    // mixed traffic
    la = 20'h13579;
    for (int i = 0; i < 40; i++) begin
      la = {la[18:0], la[19] ^ la[16]};
      access(i % 3 == 0, {la[19:4], 4'(i % 4)}, la[7:0] ^ 8'(i));
      if (i % 5 == 0) quiet(1);
    end
    drain; quiet(3);
    if (!done_flag) begin
      done_flag = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    #(200000 * CLK_NS);
    if (!done_flag) begin
      done_flag = 1;
      fails++;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule